// File: doc/BRIEF.md
# UART Transmit Character Queue with Status Flags

This block buffers outgoing characters between a processor write port and a serial transmit shifter. Software appends one byte per write strobe, and the shifter takes the oldest byte whenever it reports itself idle. The queue holds up to 24 characters. When it is full it drops further writes rather than overwriting what it already holds.

Alongside the data path the block reports how many characters are waiting. It also drives three flags. One says there is room for another write. One says the whole transmit path, queue and shifter together, has run dry. One says the number of free slots has reached a level that software programs. The room flag and the level flag each feed an interrupt output that has its own enable. The bit-level serialiser is not part of the block: it is seen only through a busy input and a take strobe.

Top module: `uart_tx_queue`

## Requirements
- R1: While `rst` is high at a rising edge, the queue empties. From the next cycle `count` is 0, `tx_ready` is 1, `pop` is 0, and `tx_empty` is 1 whenever `shifter_busy` is 0.
- R2: A write (`wr_en` high at a rising edge while `tx_ready` is 1) appends `wr_data` at the tail. Characters later appear on `pop_data` strictly in write order, and `count` rises by one in the cycle after the edge when no take happens at that edge.
- R3: `tx_ready` is 1 exactly when `count` is below 24. A write while `count` is 24 is ignored: the byte is never emitted, and with no take `count` stays 24.
- R4: `pop` is 1 in a cycle exactly when `shifter_busy` is 0 and `count` is nonzero. `pop_data` then carries the oldest character, and `count` falls by one after that edge when no write is accepted at the same edge.
- R5: An accepted write and a take at the same edge leave `count` unchanged. A write arriving at a full queue in the same cycle as a take is still ignored, because acceptance depends on the room flag from before the edge.
- R6: `tx_empty` is 1 exactly when `count` is 0 and `shifter_busy` is 0. No take ever happens while it is 1.
- R7: `count` always lies in the range 0 to 24.
- R8: `lvl_reached` is 1 exactly when (24 − `count`) ≥ `level_cfg`, re-evaluated every cycle. A level of 0 always holds, and a level above 24 never does.
- R9: `rdy_irq` equals `tx_ready` AND `rdy_irq_en`, and `lvl_irq` equals `lvl_reached` AND `lvl_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the processor |
| wr_data | input | 8 | Character to append |
| shifter_busy | input | 1 | Transmit shifter is still sending a character |
| level_cfg | input | 5 | Free-slot level for the threshold flag |
| rdy_irq_en | input | 1 | Enable for the room interrupt |
| lvl_irq_en | input | 1 | Enable for the level interrupt |
| pop | output | 1 | Shifter takes `pop_data` at this edge |
| pop_data | output | 8 | Oldest queued character |
| count | output | 5 | Characters waiting, 0 to 24 |
| tx_ready | output | 1 | At least one slot is free |
| tx_empty | output | 1 | Queue and shifter both drained |
| lvl_reached | output | 1 | Free slots at or above `level_cfg` |
| rdy_irq | output | 1 | Room interrupt |
| lvl_irq | output | 1 | Level interrupt |

## Verification
The flags, the interrupts, `pop` and `pop_data` are combinational functions of the registered occupancy and the current inputs. They are due in the same cycle as the input that moves them. `count` and the queue contents move only at a rising edge, so they are due one cycle after a write or a take. The bench changes inputs on the falling edge. It reads combinational results 1 ns after the change, and registered results at the next falling edge, after exactly one rising edge has passed.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    // Bits needed to hold an occupancy from 0 to depth inclusive.
    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    // Bits needed to address depth slots.
    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Status bundle produced by the flag logic.
    typedef struct packed {
        logic room;     // space for one more character
        logic drained;  // queue and shifter idle
        logic level;    // free slots at or above programmed level
    } txq_flag_t;

endpackage

// File: rtl/uart_txq_ptr.sv
module uart_txq_ptr #(
    parameter int unsigned DEPTH = 24,
    localparam int unsigned PTR_W = uart_txq_pkg::ptr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
    parameter int unsigned DEPTH  = 24,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = uart_txq_pkg::cnt_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shifter_busy,
    output logic              push_fire,
    output logic              pop_fire,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  fill
);
    localparam int unsigned PTR_W = uart_txq_pkg::ptr_bits(DEPTH);
    localparam int unsigned WR_SIDE = 0;
    localparam int unsigned RD_SIDE = 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slots;
        logic [CNT_W-1:0]             fill;
    } store_state_t;

    store_state_t st_d, st_q;

    logic [1:0]            adv;
    logic [1:0][PTR_W-1:0] ptrs;

    // One wrapping pointer for the tail and one for the head.
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        uart_txq_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk (clk),
            .rst (rst),
            .adv (adv[g]),
            .ptr (ptrs[g])
        );
    end

    logic push, take;

    always_comb begin
        // Acceptance uses the occupancy held before this edge.
        push = wr_en && (st_q.fill != FULL_CNT);
        take = !shifter_busy && (st_q.fill != '0);

        st_d = st_q;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (push && (ptrs[WR_SIDE] == PTR_W'(i))) begin
                st_d.slots[i] = wr_data;
            end
        end

        case ({push, take})
            2'b10:   st_d.fill = st_q.fill + 1'b1;
            2'b01:   st_d.fill = st_q.fill - 1'b1;
            default: st_d.fill = st_q.fill;
        endcase

        adv[WR_SIDE] = push;
        adv[RD_SIDE] = take;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign push_fire = push;
    assign pop_fire  = take;
    assign head      = st_q.slots[ptrs[RD_SIDE]];
    assign fill      = st_q.fill;
endmodule

// File: rtl/uart_txq_flags.sv
module uart_txq_flags #(
    parameter int unsigned DEPTH = 24,
    localparam int unsigned CNT_W = uart_txq_pkg::cnt_bits(DEPTH)
) (
    input  logic                   shifter_busy,
    input  logic [CNT_W-1:0]       fill,
    input  logic [CNT_W-1:0]       level_cfg,
    input  logic                   rdy_irq_en,
    input  logic                   lvl_irq_en,
    output uart_txq_pkg::txq_flag_t flags,
    output logic                   rdy_irq,
    output logic                   lvl_irq
);
    import uart_txq_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_d;
    txq_flag_t        flags_d;

    always_comb begin
        free_d          = FULL_CNT - fill;
        flags_d.room    = (fill != FULL_CNT);
        flags_d.drained = (fill == '0) && !shifter_busy;
        flags_d.level   = (free_d >= level_cfg);
    end

    assign flags   = flags_d;
    assign rdy_irq = flags_d.room  && rdy_irq_en;
    assign lvl_irq = flags_d.level && lvl_irq_en;
endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
    parameter int unsigned DEPTH  = 24,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = uart_txq_pkg::cnt_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shifter_busy,
    input  logic [CNT_W-1:0]  level_cfg,
    input  logic              rdy_irq_en,
    input  logic              lvl_irq_en,
    output logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              lvl_reached,
    output logic              rdy_irq,
    output logic              lvl_irq
);
    import uart_txq_pkg::*;

    logic             push_fire;
    logic             pop_fire;
    logic [CNT_W-1:0] fill;
    txq_flag_t        flags;

    uart_txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .shifter_busy (shifter_busy),
        .push_fire    (push_fire),
        .pop_fire     (pop_fire),
        .head         (pop_data),
        .fill         (fill)
    );

    uart_txq_flags #(.DEPTH(DEPTH)) u_flags (
        .shifter_busy (shifter_busy),
        .fill         (fill),
        .level_cfg    (level_cfg),
        .rdy_irq_en   (rdy_irq_en),
        .lvl_irq_en   (lvl_irq_en),
        .flags        (flags),
        .rdy_irq      (rdy_irq),
        .lvl_irq      (lvl_irq)
    );

    logic unused_push;
    assign unused_push = push_fire;

    assign pop         = pop_fire;
    assign count       = fill;
    assign tx_ready    = flags.room;
    assign tx_empty    = flags.drained;
    assign lvl_reached = flags.level;
endmodule

// File: rtl/uart_tx_queue_chk.sv
module uart_tx_queue_chk #(
    parameter int unsigned DEPTH = 24,
    localparam int unsigned CNT_W = uart_txq_pkg::cnt_bits(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             pop,
    input logic [CNT_W-1:0] count,
    input logic             tx_ready,
    input logic             tx_empty,
    input logic             lvl_reached,
    input logic             rdy_irq,
    input logic             lvl_irq
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count == '0) && tx_ready);

    assert_push_count_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_ready && !pop) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT && !pop) |=> (count == FULL_CNT));

    assert_pop_count_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && !(wr_en && tx_ready)) |=> (count == CNT_W'($past(count) - 1'b1)));

    assert_balance_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_ready && pop) |=> $stable(count));

    assert_empty_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> !pop);

    assert_count_range_R7: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    assert_irq_gating_R9: assert property (@(posedge clk) disable iff (rst)
        (!rdy_irq || tx_ready) && (!lvl_irq || lvl_reached));
endmodule

bind uart_tx_queue uart_tx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .pop         (pop),
    .count       (count),
    .tx_ready    (tx_ready),
    .tx_empty    (tx_empty),
    .lvl_reached (lvl_reached),
    .rdy_irq     (rdy_irq),
    .lvl_irq     (lvl_irq)
);

// File: tb/uart_tx_queue_bench.sv
`timescale 1ns/1ps
module uart_tx_queue_bench;
    localparam int DEPTH = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       shifter_busy = 1'b1;
    logic [4:0] level_cfg = '0;
    logic       rdy_irq_en = 1'b0;
    logic       lvl_irq_en = 1'b0;
    logic       pop;
    logic [7:0] pop_data;
    logic [4:0] count;
    logic       tx_ready, tx_empty, lvl_reached, rdy_irq, lvl_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] model[$];

    always #4 clk = ~clk;   // 125 MHz

    uart_tx_queue u_uart_tx_queue (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .shifter_busy(shifter_busy), .level_cfg(level_cfg),
        .rdy_irq_en(rdy_irq_en), .lvl_irq_en(lvl_irq_en),
        .pop(pop), .pop_data(pop_data), .count(count),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .lvl_reached(lvl_reached),
        .rdy_irq(rdy_irq), .lvl_irq(lvl_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; shifter_busy = 1'b0;
        model.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // Append with the shifter held busy so no take interferes.
    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        if (model.size() < DEPTH) model.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    // Let the shifter take exactly one character.
    task automatic take_one(input string req);
        shifter_busy = 1'b0;
        #1;
        check({req, " pop"}, pop, 1);
        check({req, " pop_data"}, pop_data, model[0]);
        void'(model.pop_front());
        @(negedge clk);
        shifter_busy = 1'b1;
        #1;
        check({req, " count"}, count, model.size());
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count, 0);
        check("R1 tx_ready", tx_ready, 1);
        check("R1 pop", pop, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R6 empty idle", tx_empty, 1);
    endtask

    task automatic t_fill_drain();
        do_reset();
        shifter_busy = 1'b1; rdy_irq_en = 1'b1;
        #1;
        check("R6 busy not empty", tx_empty, 0);
        check("R9 rdy_irq room", rdy_irq, 1);
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(i * 7 + 3));
            check("R2 count step", count, i + 1);
        end
        check("R7 count max", count, 24);
        check("R3 tx_ready full", tx_ready, 0);
        check("R9 rdy_irq full", rdy_irq, 0);
        check("R4 no pop busy", pop, 0);
        push(8'hEE);
        check("R3 write ignored", count, 24);
        // Take and write at the full boundary: write still dropped.
        shifter_busy = 1'b0; wr_en = 1'b1; wr_data = 8'h55;
        #1;
        check("R5 pop at full", pop, 1);
        check("R5 head at full", pop_data, model[0]);
        void'(model.pop_front());
        @(negedge clk);
        wr_en = 1'b0; shifter_busy = 1'b1;
        #1;
        check("R5 full write dropped", count, 23);
        for (int i = 1; i < DEPTH; i++) take_one("R2 R4 drain");
        check("R6 busy after drain", tx_empty, 0);
        shifter_busy = 1'b0;
        #1;
        check("R6 drained", tx_empty, 1);
        check("R6 no pop empty", pop, 0);
        rdy_irq_en = 1'b0;
        #1;
        check("R9 rdy_irq masked", rdy_irq, 0);
        shifter_busy = 1'b1;
    endtask

    task automatic t_simultaneous();
        do_reset();
        shifter_busy = 1'b1;
        push(8'hA1); push(8'hA2); push(8'hA3);
        shifter_busy = 1'b0; wr_en = 1'b1; wr_data = 8'hB4;
        #1;
        check("R5 pop", pop, 1);
        check("R5 pop_data", pop_data, 8'hA1);
        void'(model.pop_front());
        model.push_back(8'hB4);
        @(negedge clk);
        wr_en = 1'b0; shifter_busy = 1'b1;
        #1;
        check("R5 count held", count, 3);
        for (int i = 0; i < 3; i++) take_one("R2 order");
    endtask

    task automatic t_level();
        do_reset();
        shifter_busy = 1'b1;
        level_cfg = 5'd0;  #1; check("R8 level zero", lvl_reached, 1);
        level_cfg = 5'd25; #1; check("R8 level above depth", lvl_reached, 0);
        level_cfg = 5'd24; #1; check("R8 level full free", lvl_reached, 1);
        push(8'h11);
        check("R8 level 24 one used", lvl_reached, 0);
        level_cfg = 5'd10;
        for (int i = 1; i < 14; i++) push(8'(i));
        check("R8 free 10 of 10", lvl_reached, 1);
        lvl_irq_en = 1'b1; #1;
        check("R9 lvl_irq on", lvl_irq, 1);
        lvl_irq_en = 1'b0; #1;
        check("R9 lvl_irq masked", lvl_irq, 0);
        lvl_irq_en = 1'b1;
        push(8'h99);
        check("R8 free 9 of 10", lvl_reached, 0);
        check("R9 lvl_irq off", lvl_irq, 0);
        lvl_irq_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_simultaneous();
        t_level();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule